// File: doc/BRIEF.md
# Sign-Selective Twiddle Real-Part Encoder

This block sits between a twiddle-factor source and a complex multiplier. On every valid beat it may present the real part of the incoming coefficient either as received or negated in two's complement. It picks the form whose bit pattern differs in fewer positions from the real word it presented on the last valid beat. Fewer bits change at the multiplier's coefficient port from one beat to the next, so that port toggles less. The imaginary part is never altered. A one-bit negate flag leaves the block together with each coefficient.

The multiplier outside the block forms the four partial products, and it hands them back with the flag of the coefficient they came from. A correction stage inside this block negates the two terms built from the real part whenever the flag is set. It then adds them into the true complex product. The encoder has one cycle of latency, and so does the correction stage. A synchronous clear makes the next comparison start again from an all-zero reference.

Top module: `twiddle_flip_enc`

## Requirements
- R1: On each valid beat, out_im equals in_im one cycle later, unchanged.
- R2: One cycle after a valid beat, out_re equals in_re (out_neg = 0) or the W-bit two's complement negation of in_re (out_neg = 1).
- R3: The form chosen has the smaller Hamming distance to the real word presented on the previous valid beat. When the two distances are equal, the non-negated form (out_neg = 0) is chosen.
- R4: The first valid beat after reset, or after a clr pulse, is compared against an all-zero reference. When clr and in_valid are high in the same cycle, that beat is compared against zero.
- R5: A real part equal to the most negative value (sign bit 1, all other bits 0; 16'h8000 for W = 16) is never negated, so out_neg stays 0.
- R6: out_valid equals in_valid delayed by one cycle. After reset, out_valid, out_re, out_im, out_neg, corr_valid, corr_re and corr_im are all zero.
- R7: In a cycle with in_valid low, out_re, out_im and out_neg hold their values and the comparison reference does not change.
- R8: One cycle after prod_valid, corr_valid is 1 and the outputs are corr_re = s·prod_ac − prod_bd and corr_im = prod_ad + s·prod_bc, where s = −1 when prod_neg = 1 and s = +1 otherwise. When prod_valid is low, corr_valid is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Resets the comparison reference to zero |
| in_valid | input | 1 | Coefficient beat valid |
| in_re | input | W | Coefficient real part, signed |
| in_im | input | W | Coefficient imaginary part, signed |
| out_valid | output | 1 | Encoded coefficient valid |
| out_re | output | W | Presented real part |
| out_im | output | W | Imaginary part |
| out_neg | output | 1 | Set when out_re is the negated form |
| prod_valid | input | 1 | Partial products valid |
| prod_neg | input | 1 | Negate flag carried with the products |
| prod_ac | input | 2W | Data real × presented coefficient real |
| prod_bc | input | 2W | Data imaginary × presented coefficient real |
| prod_ad | input | 2W | Data real × coefficient imaginary |
| prod_bd | input | 2W | Data imaginary × coefficient imaginary |
| corr_valid | output | 1 | Corrected product valid |
| corr_re | output | 2W+1 | Corrected product real part |
| corr_im | output | 2W+1 | Corrected product imaginary part |

## Verification
A clear and a valid coefficient beat can arrive in the same cycle. The stimulus for this is chosen so that comparing against zero selects the negated form, while comparing against the previously presented word selects the normal form. The outcome therefore shows which reference was used. A clear with no beat is also covered: the block must hold its outputs during that cycle, and the next beat must then be judged against zero. The correction stage receives products built by the bench from presented coefficients, with the flag both set and clear. Its results are compared with the true complex product.

// File: rtl/twiddle_flip_enc.sv
`timescale 1ns/1ps
module twiddle_flip_enc #(
  parameter int W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  in_valid,
  input  logic signed [W-1:0]   in_re,
  input  logic signed [W-1:0]   in_im,
  output logic                  out_valid,
  output logic signed [W-1:0]   out_re,
  output logic signed [W-1:0]   out_im,
  output logic                  out_neg,
  input  logic                  prod_valid,
  input  logic                  prod_neg,
  input  logic signed [2*W-1:0] prod_ac,
  input  logic signed [2*W-1:0] prod_bc,
  input  logic signed [2*W-1:0] prod_ad,
  input  logic signed [2*W-1:0] prod_bd,
  output logic                  corr_valid,
  output logic signed [2*W:0]   corr_re,
  output logic signed [2*W:0]   corr_im
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  function automatic logic [CW-1:0] ones(input logic [W-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  logic [W-1:0]  prev_q;
  logic [W-1:0]  ref_w, flip_w, pick_w;
  logic [CW-1:0] dist_keep, dist_flip;
  logic          take_flip;

  assign ref_w     = clr ? '0 : prev_q;
  assign flip_w    = -in_re;
  assign dist_keep = ones(in_re ^ ref_w);
  assign dist_flip = ones(flip_w ^ ref_w);
  assign take_flip = (in_re != MOST_NEG) && (dist_flip < dist_keep);
  assign pick_w    = take_flip ? flip_w : in_re;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      out_neg   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        prev_q  <= pick_w;
        out_re  <= pick_w;
        out_im  <= in_im;
        out_neg <= take_flip;
      end else if (clr) begin
        prev_q  <= '0;
      end
    end
  end

  logic signed [2*W:0] ac_x, bc_x, ad_x, bd_x;

  assign ac_x = prod_neg ? -{prod_ac[2*W-1], prod_ac} : {prod_ac[2*W-1], prod_ac};
  assign bc_x = prod_neg ? -{prod_bc[2*W-1], prod_bc} : {prod_bc[2*W-1], prod_bc};
  assign ad_x = {prod_ad[2*W-1], prod_ad};
  assign bd_x = {prod_bd[2*W-1], prod_bd};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corr_valid <= 1'b0;
      corr_re    <= '0;
      corr_im    <= '0;
    end else begin
      corr_valid <= prod_valid;
      if (prod_valid) begin
        corr_re <= ac_x - bd_x;
        corr_im <= ad_x + bc_x;
      end
    end
  end
endmodule

module twiddle_flip_enc_chk #(
  parameter int W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr,
  input logic                  in_valid,
  input logic signed [W-1:0]   in_re,
  input logic signed [W-1:0]   in_im,
  input logic                  out_valid,
  input logic signed [W-1:0]   out_re,
  input logic signed [W-1:0]   out_im,
  input logic                  out_neg,
  input logic                  prod_valid,
  input logic                  prod_neg,
  input logic signed [2*W-1:0] prod_ac,
  input logic signed [2*W-1:0] prod_bc,
  input logic signed [2*W-1:0] prod_ad,
  input logic signed [2*W-1:0] prod_bd,
  input logic                  corr_valid,
  input logic signed [2*W:0]   corr_re,
  input logic signed [2*W:0]   corr_im
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  a_r1_imag_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_im == $past(in_im));

  a_r2_real_form: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_neg ? (out_re == W'(-$past(in_re))) : (out_re == $past(in_re))));

  a_r5_no_min_negate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_re == MOST_NEG) |=> !out_neg);

  a_r6_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r6_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_re) && $stable(out_im) && $stable(out_neg)));

  a_r8_corr_valid: assert property (@(posedge clk) disable iff (!rst_n)
    prod_valid |=> corr_valid);

  a_r8_corr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !prod_valid |=> !corr_valid);
endmodule

bind twiddle_flip_enc twiddle_flip_enc_chk #(.W(W)) chk_i (.*);

// File: tb/twiddle_flip_enc_tb_top.sv
`timescale 1ns/1ps
module twiddle_flip_enc_tb_top;
  localparam int W = 16;
  localparam logic [W-1:0] MOST_NEG = 16'h8000;

  logic clk = 1'b0;
  logic rst_n, clr, in_valid, prod_valid, prod_neg;
  logic signed [W-1:0] in_re, in_im;
  logic out_valid, out_neg, corr_valid;
  logic signed [W-1:0] out_re, out_im;
  logic signed [2*W-1:0] prod_ac, prod_bc, prod_ad, prod_bd;
  logic signed [2*W:0] corr_re, corr_im;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [W-1:0] prev_m = '0;

  always #2 clk = ~clk;

  twiddle_flip_enc #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_re(out_re),
    .out_im(out_im), .out_neg(out_neg), .prod_valid(prod_valid),
    .prod_neg(prod_neg), .prod_ac(prod_ac), .prod_bc(prod_bc),
    .prod_ad(prod_ad), .prod_bd(prod_bd), .corr_valid(corr_valid),
    .corr_re(corr_re), .corr_im(corr_im)
  );

  task automatic check(input string req, input bit ok,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [W-1:0] re, input logic [W-1:0] im,
                      input logic c, input string req, output logic flg);
    logic [W-1:0] refv, flp, exp_re;
    int dk, df;
    refv = c ? '0 : prev_m;
    flp = -re;
    dk = $countones(re ^ refv);
    df = $countones(flp ^ refv);
    flg = (re != MOST_NEG) && (df < dk);
    exp_re = flg ? flp : re;
    prev_m = exp_re;
    @(negedge clk);
    in_valid = 1'b1; in_re = re; in_im = im; clr = c;
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0; in_re = 16'h5A5A; in_im = 16'hA5A5;
    check(req, out_valid && out_re == exp_re && out_im == im && out_neg == flg,
          {15'd0, out_valid, out_re, out_im, 15'd0, out_neg},
          {15'd0, 1'b1, exp_re, im, 15'd0, flg});
  endtask

  task automatic t_reset;
    check("R6 reset", !out_valid && out_re == 0 && out_im == 0 && !out_neg &&
          !corr_valid && corr_re == 0 && corr_im == 0,
          {out_valid, out_neg, corr_valid, out_re, out_im}, 64'd0);
  endtask

  task automatic t_basic;
    logic f;
    beat(16'hFFFF, 16'h1234, 1'b0, "R2 R3 negate all-ones", f);
    check("R3 all-ones vs zero negated", f == 1'b1, {63'd0, f}, 64'd1);
    beat(16'h0001, 16'h0042, 1'b0, "R1 R2 keep one", f);
    check("R3 one vs one kept", f == 1'b0, {63'd0, f}, 64'd0);
    beat(16'h01FE, 16'h0000, 1'b1, "R3 tie setup", f);
    check("R3 tie keeps normal", f == 1'b0, {63'd0, f}, 64'd0);
  endtask

  task automatic t_min;
    logic f;
    beat(16'h7FFF, 16'h0001, 1'b0, "R5 setup", f);
    beat(MOST_NEG, 16'h0002, 1'b0, "R5 most negative", f);
    check("R5 most negative not negated", f == 1'b0, {63'd0, f}, 64'd0);
  endtask

  task automatic t_hold;
    logic f;
    logic [W-1:0] held;
    beat(16'h7FF0, 16'h0303, 1'b0, "R7 setup", f);
    held = out_re;
    repeat (3) @(negedge clk);
    check("R7 outputs hold while idle", !out_valid && out_re == held && out_im == 16'h0303,
          {out_valid, out_re, out_im}, {1'b0, held, 16'h0303});
    beat(16'h800F, 16'h0404, 1'b0, "R7 reference unchanged over gap", f);
  endtask

  task automatic t_clr;
    logic f;
    beat(MOST_NEG, 16'h0001, 1'b0, "R4 setup a", f);
    beat(16'hC000, 16'h0011, 1'b1, "R4 clr with beat", f);
    check("R4 clr with beat judged against zero", f == 1'b1, {63'd0, f}, 64'd1);
    beat(MOST_NEG, 16'h0001, 1'b0, "R4 setup b", f);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R4 R7 clr alone keeps outputs", out_re == MOST_NEG && !out_neg,
          {out_re, out_neg}, {MOST_NEG, 1'b0});
    prev_m = '0;
    beat(16'hC000, 16'h0022, 1'b0, "R4 beat after clr", f);
    check("R4 beat after clr negated", f == 1'b1, {63'd0, f}, 64'd1);
  endtask

  task automatic t_stream;
    logic [W-1:0] lf;
    logic f;
    lf = 16'hACE1;
    for (int i = 0; i < 48; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      beat(lf, ~lf, 1'b0, "R2 R3 stream", f);
      if (i % 7 == 3) @(negedge clk);
    end
  endtask

  task automatic corr_case(input logic signed [W-1:0] a, b, c, d, input logic flg);
    logic signed [W-1:0] cp;
    logic signed [2*W:0] er, ei;
    cp = flg ? -c : c;
    er = (2*W+1)'(a * c) - (2*W+1)'(b * d);
    ei = (2*W+1)'(a * d) + (2*W+1)'(b * c);
    @(negedge clk);
    prod_valid = 1'b1; prod_neg = flg;
    prod_ac = a * cp; prod_bc = b * cp; prod_ad = a * d; prod_bd = b * d;
    @(negedge clk);
    prod_valid = 1'b0;
    check("R8 corrected product", corr_valid && corr_re == er && corr_im == ei,
          {corr_valid, corr_re[30:0], corr_im[31:0]}, {1'b1, er[30:0], ei[31:0]});
  endtask

  task automatic t_corr;
    corr_case(16'sd1200, -16'sd700, 16'sd30000, -16'sd12000, 1'b0);
    corr_case(16'sd1200, -16'sd700, 16'sd30000, -16'sd12000, 1'b1);
    corr_case(-16'sd32768, 16'sd32767, -16'sd32767, 16'sd5, 1'b1);
    corr_case(16'sd77, 16'sd99, -16'sd1, 16'sd32767, 1'b1);
    @(negedge clk);
    check("R8 corr_valid drops", !corr_valid, {63'd0, corr_valid}, 64'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; in_re = '0; in_im = '0;
    prod_valid = 1'b0; prod_neg = 1'b0;
    prod_ac = '0; prod_bc = '0; prod_ad = '0; prod_bd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_min();
    t_hold();
    t_clr();
    t_stream();
    t_corr();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule